// File: doc/BRIEF.md
# Interrupt Source Controller with Redelivery

This block owns a bank of interrupt sources and turns their activity into offers for a presentation unit. Each source is typed once as either level-sensitive or message-signalled. For each source the block keeps a target server, a priority and a saved priority. It also keeps four status bits: asserted, sent, rejected and masked-pending. The all-ones priority (0xFF) masks a source. Every offer carries the global interrupt number (source index plus a base parameter), the target server and the priority. Several presentation units can share the offer port because each offer names its server.

The presentation side sends three kinds of notification back: reject, end-of-interrupt (EOI) and resend. The two source types recover from these in different ways. A message-signalled source remembers that it was rejected and is offered again during the next resend scan. A level-sensitive source is offered again whenever it is still asserted and no earlier offer is outstanding. Software changes a source's server and priority with a configuration write, and that write can release an event held back while the source was masked.

Offers that become ready in the same cycle leave one per cycle, lowest source index first. A resend visits one source per cycle.

Top module: `irq_source_unit`

## Requirements
- R1: After `rst_n` is low, every priority and saved priority is 0xFF, all status bits and queued offers are cleared, and no offer is made. Source types survive `rst_n` and are cleared only by `por_n`.
- R2: An offer drives `offer_vld` high for one cycle. It carries `offer_num` = BASE + source index, together with that source's server and priority. It appears two clock edges after the edge that sampled the causing input.
- R3: A message-signalled event (`msg_pulse` bit) on a masked source sets masked-pending and makes no offer. On an unmasked source it queues an offer. No offer ever carries priority 0xFF.
- R4: A configuration write stores server, priority and saved priority. If the source is message-signalled and masked-pending, and the new priority is not 0xFF, the write clears masked-pending and queues an offer. A write to a source with nothing pending makes no offer.
- R5: A level-sensitive source copies its `lvl_in` bit into the asserted bit. When the input changes, the source is offered only if it is unmasked, asserted and not sent, and the sent bit is set at the moment the offer is queued. It is never offered twice while sent.
- R6: A reject for a message-signalled source sets its rejected bit. A reject for a level-sensitive source clears its sent bit. Neither produces an offer by itself.
- R7: A resend walks the sources one per cycle, starting at index 0. A rejected message-signalled source has its rejected bit cleared and is offered again if unmasked. A masked one is dropped. A level-sensitive source follows the R5 rule. A resend request during a scan is ignored.
- R8: An EOI clears the sent bit of a level-sensitive source, so that the next resend can offer it again. It has no effect on a message-signalled source.
- R9: Offers queued in the same cycle leave one per cycle, lowest source index first.
- R10: A reject or EOI whose number lies outside BASE to BASE+NUM_SRC-1 changes nothing.
- R11: A source's type can be set only once. Setting it again raises `err_retype` for one cycle, one edge after the request, and leaves the type unchanged. An untyped source never makes an offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; keeps source types |
| por_n | input | 1 | Synchronous active-low power-on reset; also clears source types |
| type_vld | input | 1 | Request to set a source type |
| type_idx | input | IDX_W | Source index for the type request |
| type_lvl | input | 1 | 1 = level-sensitive, 0 = message-signalled |
| err_retype | output | 1 | One-cycle pulse: type set on an already typed source |
| lvl_in | input | NUM_SRC | Level inputs; a bit is used only by a level-sensitive source |
| msg_pulse | input | NUM_SRC | Event pulses; a bit is used only by a message-signalled source |
| cfg_vld | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for the configuration write |
| cfg_srv | input | SRV_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| rej_vld | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Interrupt number being rejected |
| eoi_vld | input | 1 | EOI notification strobe |
| eoi_num | input | NUM_W | Interrupt number being completed |
| resend_req | input | 1 | Start a resend scan |
| offer_vld | output | 1 | Offer valid |
| offer_num | output | NUM_W | Offered interrupt number |
| offer_srv | output | SRV_W | Target server of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The collision that matters most is a message-signalled event and a level-sensitive input rise landing in the same cycle. The bench provokes it with one pulse on a low message source and a rise on a higher level source, driven from the same cycle. It judges the result by the order of the two offers in the scoreboard queue: the lower index must come first, and each offer must carry its own server and priority. The same ordering is checked for two simultaneous message events and for a resend scan that finds two rejected sources. Any offer the queue does not expect is reported as a failure.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
   localparam int PRIO_W = 8;
   localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

   // per-source status bits
   typedef struct packed {
      logic asserted;
      logic sent;
      logic rejected;
      logic mpend;
   } src_stat_t;
endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
   import irqsrc_pkg::*;
#(
   parameter int SRV_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              type_hit,
   input  logic              type_lvl,
   output logic              retype,
   input  logic              lvl_in,
   input  logic              msg_ev,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_srv,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [PRIO_W-1:0] cfg_saved,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              scan_hit,
   input  logic              grant,
   output logic              req,
   output logic [SRV_W-1:0]  srv,
   output logic [PRIO_W-1:0] prio
);
   logic              typed_q, lvl_q;
   src_stat_t         st_q, st_n;
   logic              q_q, q_n;
   logic [PRIO_W-1:0] prio_q, prio_n, sav_q, sav_n;
   logic [SRV_W-1:0]  srv_q, srv_n;
   logic              lvl_t, msi_t, unm, lvl_chg;

   assign lvl_t  = typed_q & lvl_q;
   assign msi_t  = typed_q & ~lvl_q;
   assign retype = type_hit & typed_q;

   // type register: survives soft reset
   always_ff @(posedge clk) begin
      if (!por_n) begin
         typed_q <= 1'b0;
         lvl_q   <= 1'b0;
      end else if (type_hit && !typed_q) begin
         typed_q <= 1'b1;
         lvl_q   <= type_lvl;
      end
   end

   always_comb begin
      st_n   = st_q;
      q_n    = q_q & ~grant;
      prio_n = prio_q;
      srv_n  = srv_q;
      sav_n  = sav_q;
      if (cfg_hit) begin
         prio_n = cfg_prio;
         srv_n  = cfg_srv;
         sav_n  = cfg_saved;
      end
      unm = (prio_n != PRIO_OFF);
      if (rej_hit) begin
         if (msi_t) st_n.rejected = 1'b1;
         if (lvl_t) st_n.sent     = 1'b0;
      end
      if (eoi_hit && lvl_t) st_n.sent = 1'b0;
      if (msi_t && msg_ev) begin
         if (unm) q_n = 1'b1;
         else     st_n.mpend = 1'b1;
      end
      if (msi_t && cfg_hit && st_n.mpend && unm) begin
         st_n.mpend = 1'b0;
         q_n        = 1'b1;
      end
      if (msi_t && scan_hit && st_n.rejected) begin
         st_n.rejected = 1'b0;
         if (unm) q_n = 1'b1;
      end
      lvl_chg = lvl_t && (lvl_in != st_q.asserted);
      if (lvl_t) st_n.asserted = lvl_in;
      if (lvl_t && (lvl_chg || cfg_hit || scan_hit) && unm &&
          st_n.asserted && !st_n.sent) begin
         st_n.sent = 1'b1;
         q_n       = 1'b1;
      end
      // masking a source withdraws an offer not yet sent out
      if (cfg_hit && !unm && q_n) begin
         q_n = 1'b0;
         if (msi_t) st_n.mpend = 1'b1;
         if (lvl_t) st_n.sent  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         st_q   <= '0;
         q_q    <= 1'b0;
         prio_q <= PRIO_OFF;
         sav_q  <= PRIO_OFF;
         srv_q  <= '0;
      end else begin
         st_q   <= st_n;
         q_q    <= q_n;
         prio_q <= prio_n;
         sav_q  <= sav_n;
         srv_q  <= srv_n;
      end
   end

   assign req  = q_q;
   assign srv  = srv_q;
   assign prio = prio_q;

   assert_lvl_offer_marks_sent_R5: assert property (@(posedge clk)
      disable iff (!rst_n || !por_n) ($rose(q_q) && lvl_t) |-> st_q.sent);

   assert_saved_written_R4: assert property (@(posedge clk)
      disable iff (!rst_n || !por_n) cfg_hit |=> (sav_q == $past(cfg_saved)));

   assert_masked_event_pends_R3: assert property (@(posedge clk)
      disable iff (!rst_n || !por_n)
      (msi_t && msg_ev && !cfg_hit && prio_q == PRIO_OFF) |=> (st_q.mpend && !q_q));
endmodule

// File: rtl/irqsrc_pick.sv
module irqsrc_pick #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req,
   output logic [NUM_SRC-1:0] grant,
   output logic [IDX_W-1:0]   idx,
   output logic               any
);
   localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |req;
   assign grant = req & (~req + ONE);

   assert_grant_onehot_R9: assert property (@(posedge clk)
      disable iff (!rst_n) $onehot0(grant));

   assert_lowest_first_R9: assert property (@(posedge clk)
      disable iff (!rst_n) any |-> (((grant - ONE) & req) == '0 && grant[idx]));
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
   parameter int NUM_SRC = 8,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic [NUM_SRC-1:0] hit
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

   logic             act_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         idx_q <= '0;
      end else if (!act_q) begin
         if (start) begin
            act_q <= 1'b1;
            idx_q <= '0;
         end
      end else begin
         if (idx_q == LAST) act_q <= 1'b0;
         idx_q <= idx_q + 1'b1;
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
      assign hit[i] = act_q && (idx_q == IDX_W'(i));
   end

   assert_scan_bound_R7: assert property (@(posedge clk)
      disable iff (!rst_n) act_q |-> (idx_q <= LAST));

   assert_scan_steps_R7: assert property (@(posedge clk)
      disable iff (!rst_n) (act_q && idx_q != LAST) |=>
         (act_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/irq_source_unit.sv
module irq_source_unit
   import irqsrc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int BASE    = 16,
   parameter int NUM_W   = 12,
   parameter int SRV_W   = 4,
   localparam int IDX_W  = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               por_n,
   input  logic               type_vld,
   input  logic [IDX_W-1:0]   type_idx,
   input  logic               type_lvl,
   output logic               err_retype,
   input  logic [NUM_SRC-1:0] lvl_in,
   input  logic [NUM_SRC-1:0] msg_pulse,
   input  logic               cfg_vld,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [SRV_W-1:0]   cfg_srv,
   input  logic [7:0]         cfg_prio,
   input  logic [7:0]         cfg_saved,
   input  logic               rej_vld,
   input  logic [NUM_W-1:0]   rej_num,
   input  logic               eoi_vld,
   input  logic [NUM_W-1:0]   eoi_num,
   input  logic               resend_req,
   output logic               offer_vld,
   output logic [NUM_W-1:0]   offer_num,
   output logic [SRV_W-1:0]   offer_srv,
   output logic [7:0]         offer_prio
);
   localparam logic [NUM_W-1:0] BASE_L = NUM_W'(BASE);
   localparam logic [NUM_W-1:0] LAST_L = NUM_W'(BASE + NUM_SRC - 1);

   if (NUM_SRC < 2) begin : g_bad_count
      $error("NUM_SRC must be at least 2");
   end
   if (BASE + NUM_SRC > (1 << NUM_W)) begin : g_bad_range
      $error("BASE + NUM_SRC does not fit in NUM_W bits");
   end
   if (SRV_W < 1) begin : g_bad_srv
      $error("SRV_W must be at least 1");
   end

   logic              rst_any_n;
   logic [NUM_W-1:0]  rej_off, eoi_off;
   logic              rej_in, eoi_in;
   logic [NUM_SRC-1:0] rej_hit, eoi_hit, cfg_hit, type_hit, scan_hit;
   logic [NUM_SRC-1:0] retype_v, req_v, grant_v;
   logic [SRV_W-1:0]   srv_a  [NUM_SRC];
   logic [PRIO_W-1:0]  prio_a [NUM_SRC];
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_any;

   assign rst_any_n = rst_n & por_n;
   assign rej_off   = rej_num - BASE_L;
   assign eoi_off   = eoi_num - BASE_L;
   assign rej_in    = rej_vld && rej_num >= BASE_L && rej_num <= LAST_L;
   assign eoi_in    = eoi_vld && eoi_num >= BASE_L && eoi_num <= LAST_L;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign rej_hit[i]  = rej_in && (rej_off == NUM_W'(i));
      assign eoi_hit[i]  = eoi_in && (eoi_off == NUM_W'(i));
      assign cfg_hit[i]  = cfg_vld && (cfg_idx == IDX_W'(i));
      assign type_hit[i] = type_vld && (type_idx == IDX_W'(i));

      irqsrc_slot #(.SRV_W(SRV_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .por_n    (por_n),
         .type_hit (type_hit[i]),
         .type_lvl (type_lvl),
         .retype   (retype_v[i]),
         .lvl_in   (lvl_in[i]),
         .msg_ev   (msg_pulse[i]),
         .cfg_hit  (cfg_hit[i]),
         .cfg_srv  (cfg_srv),
         .cfg_prio (cfg_prio),
         .cfg_saved(cfg_saved),
         .rej_hit  (rej_hit[i]),
         .eoi_hit  (eoi_hit[i]),
         .scan_hit (scan_hit[i]),
         .grant    (grant_v[i]),
         .req      (req_v[i]),
         .srv      (srv_a[i]),
         .prio     (prio_a[i])
      );
   end

   irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
      .clk  (clk),
      .rst_n(rst_any_n),
      .start(resend_req),
      .hit  (scan_hit)
   );

   irqsrc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .clk  (clk),
      .rst_n(rst_any_n),
      .req  (req_v),
      .grant(grant_v),
      .idx  (pick_idx),
      .any  (pick_any)
   );

   always_ff @(posedge clk) begin
      if (!rst_any_n) begin
         offer_vld  <= 1'b0;
         offer_num  <= '0;
         offer_srv  <= '0;
         offer_prio <= PRIO_OFF;
         err_retype <= 1'b0;
      end else begin
         offer_vld  <= pick_any;
         offer_num  <= BASE_L + NUM_W'(pick_idx);
         offer_srv  <= srv_a[pick_idx];
         offer_prio <= prio_a[pick_idx];
         err_retype <= |retype_v;
      end
   end

   assert_offer_unmasked_R3: assert property (@(posedge clk)
      disable iff (!rst_any_n) offer_vld |-> (offer_prio != PRIO_OFF));

   assert_offer_in_range_R2: assert property (@(posedge clk)
      disable iff (!rst_any_n) offer_vld |-> (offer_num >= BASE_L && offer_num <= LAST_L));

   assert_retype_cause_R11: assert property (@(posedge clk)
      disable iff (!rst_any_n) err_retype |-> $past(type_vld));
endmodule

// File: tb/irq_source_unit_test.sv
module irq_source_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 8;
   localparam int BASE  = 16;
   localparam int NW    = 12;
   localparam int SW    = 4;
   localparam int IW    = $clog2(N);

   logic clk = 1'b0;
   logic rst_n, por_n, type_vld, type_lvl, cfg_vld, rej_vld, eoi_vld, resend_req;
   logic [IW-1:0] type_idx, cfg_idx;
   logic [N-1:0]  lvl_in, msg_pulse;
   logic [SW-1:0] cfg_srv;
   logic [7:0]    cfg_prio, cfg_saved;
   logic [NW-1:0] rej_num, eoi_num;
   logic          err_retype, offer_vld;
   logic [NW-1:0] offer_num;
   logic [SW-1:0] offer_srv;
   logic [7:0]    offer_prio;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [NW+SW+8-1:0] exp_q[$];
   string              tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_source_unit #(.NUM_SRC(N), .BASE(BASE), .NUM_W(NW), .SRV_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .type_vld(type_vld), .type_idx(type_idx), .type_lvl(type_lvl),
      .err_retype(err_retype), .lvl_in(lvl_in), .msg_pulse(msg_pulse),
      .cfg_vld(cfg_vld), .cfg_idx(cfg_idx), .cfg_srv(cfg_srv),
      .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
      .rej_vld(rej_vld), .rej_num(rej_num), .eoi_vld(eoi_vld), .eoi_num(eoi_num),
      .resend_req(resend_req), .offer_vld(offer_vld), .offer_num(offer_num),
      .offer_srv(offer_srv), .offer_prio(offer_prio)
   );

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic void expect_offer(int num, int srv, int prio, string tag);
      exp_q.push_back({NW'(num), SW'(srv), 8'(prio)});
      tag_q.push_back(tag);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_empty(string tag);
      settle(4);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   // monitor: compares each offer with the head of the queue
   initial begin
      forever begin
         @(negedge clk);
         if (!done && offer_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL unexpected offer: actual num=%0d srv=%0d prio=%0d, expected none",
                        offer_num, offer_srv, offer_prio);
            end else begin
               logic [NW+SW+8-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if ({offer_num, offer_srv, offer_prio} !== e) begin
                  fails++;
                  $display("FAIL %s: actual num=%0d srv=%0d prio=%0d, expected num=%0d srv=%0d prio=%0d",
                           t, offer_num, offer_srv, offer_prio,
                           e[NW+SW+7:SW+8], e[SW+7:8], e[7:0]);
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running, expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic set_type(int i, bit lvl);
      type_vld = 1'b1; type_idx = IW'(i); type_lvl = lvl;
      settle(1);
      type_vld = 1'b0;
   endtask

   task automatic cfg(int i, int srv, int prio, int sav);
      cfg_vld = 1'b1; cfg_idx = IW'(i); cfg_srv = SW'(srv);
      cfg_prio = 8'(prio); cfg_saved = 8'(sav);
      settle(1);
      cfg_vld = 1'b0;
   endtask

   task automatic pulse(int i);
      msg_pulse[i] = 1'b1;
      settle(1);
      msg_pulse = '0;
   endtask

   task automatic reject(int num);
      rej_vld = 1'b1; rej_num = NW'(num);
      settle(1);
      rej_vld = 1'b0;
   endtask

   task automatic eoi(int num);
      eoi_vld = 1'b1; eoi_num = NW'(num);
      settle(1);
      eoi_vld = 1'b0;
   endtask

   task automatic resend();
      resend_req = 1'b1;
      settle(1);
      resend_req = 1'b0;
      settle(N + 4);
   endtask

   initial begin
      rst_n = 1'b0; por_n = 1'b0;
      type_vld = 1'b0; type_idx = '0; type_lvl = 1'b0;
      cfg_vld = 1'b0; cfg_idx = '0; cfg_srv = '0; cfg_prio = '0; cfg_saved = '0;
      rej_vld = 1'b0; rej_num = '0; eoi_vld = 1'b0; eoi_num = '0;
      resend_req = 1'b0; lvl_in = '0; msg_pulse = '0;
      settle(3);
      rst_n = 1'b1; por_n = 1'b1;
      settle(1);
      // R1: reset state
      check(offer_vld == 1'b0, "R1 offer_vld after reset", offer_vld, 0);
      check(err_retype == 1'b0, "R1 err_retype after reset", err_retype, 0);

      // sources 0..3 message, 4..6 level, 7 left untyped
      for (int i = 0; i < 4; i++) set_type(i, 1'b0);
      for (int i = 4; i < 7; i++) set_type(i, 1'b1);
      check(err_retype == 1'b0, "R11 first type set no error", err_retype, 0);
      type_vld = 1'b1; type_idx = '0; type_lvl = 1'b1;
      settle(1);
      type_vld = 1'b0;
      check(err_retype == 1'b1, "R11 retype error pulse", err_retype, 1);
      settle(1);
      check(err_retype == 1'b0, "R11 error pulse one cycle", err_retype, 0);

      // R11: untyped source never offers
      cfg(7, 1, 1, 1);
      lvl_in[7] = 1'b1;
      pulse(7);
      check_empty("R11 untyped silent");

      // R3: masked message event pends; R4: config releases it
      pulse(0);
      check_empty("R3 masked event no offer");
      expect_offer(16, 2, 5, "R4 masked-pending released");
      cfg(0, 2, 5, 9);
      check_empty("R4 released offer");
      cfg(1, 3, 3, 3);
      check_empty("R4 config without pending no offer");
      expect_offer(17, 3, 3, "R3 unmasked event");
      pulse(1);
      check_empty("R3 unmasked offered");

      // R9: simultaneous events, lowest index first
      cfg(2, 1, 6, 6);
      expect_offer(17, 3, 3, "R9 lower index first");
      expect_offer(18, 1, 6, "R9 higher index second");
      msg_pulse[1] = 1'b1; msg_pulse[2] = 1'b1;
      settle(1);
      msg_pulse = '0;
      check_empty("R9 both offered");

      // R6/R7: reject then resend for message source
      reject(18);
      check_empty("R6 reject no offer");
      expect_offer(18, 1, 6, "R7 rejected message re-offered");
      resend();
      check_empty("R7 resend done");
      // rejected but masked at resend: dropped
      reject(17);
      cfg(1, 3, 8'hFF, 3);
      resend();
      cfg(1, 3, 3, 3);
      resend();
      check_empty("R7 masked rejected dropped");
      // R7: scan order
      reject(17);
      reject(16);
      expect_offer(16, 2, 5, "R7 scan order first");
      expect_offer(17, 3, 3, "R7 scan order second");
      resend();
      check_empty("R7 scan order done");
      eoi(16);
      resend();
      check_empty("R8 EOI on message no effect");

      // R5/R8: level source
      cfg(4, 5, 4, 4);
      expect_offer(20, 5, 4, "R5 level rise offered");
      lvl_in[4] = 1'b1;
      settle(1);
      check_empty("R5 level offered");
      resend();
      check_empty("R5 sent blocks re-offer");
      eoi(20);
      check_empty("R8 EOI alone no offer");
      expect_offer(20, 5, 4, "R8 EOI then resend re-offers");
      resend();
      check_empty("R8 resend done");
      lvl_in[4] = 1'b0;
      settle(1);
      eoi(20);
      resend();
      check_empty("R5 deasserted no offer");

      // level raised while masked, released by config
      lvl_in[5] = 1'b1;
      check_empty("R5 masked level no offer");
      expect_offer(21, 7, 2, "R4 config unmasks asserted level");
      cfg(5, 7, 2, 2);
      check_empty("R4 level via config");
      // R10: out of range notifications ignored
      reject(24);
      eoi(15);
      resend();
      check_empty("R10 out of range ignored");
      reject(21);
      check_empty("R6 level reject no offer");
      expect_offer(21, 7, 2, "R6 level reject then resend");
      resend();
      check_empty("R6 level resend done");

      // R9: message event and level rise in the same cycle
      cfg(6, 1, 1, 1);
      cfg(3, 4, 9, 9);
      expect_offer(19, 4, 9, "R9 message lower index first");
      expect_offer(22, 1, 1, "R9 level higher index second");
      msg_pulse[3] = 1'b1; lvl_in[6] = 1'b1;
      settle(1);
      msg_pulse = '0;
      check_empty("R9 mixed done");

      // R1: soft reset keeps types, clears config
      rst_n = 1'b0;
      settle(2);
      rst_n = 1'b1;
      settle(1);
      check(offer_vld == 1'b0, "R1 offer_vld after soft reset", offer_vld, 0);
      pulse(1);
      check_empty("R1 priorities masked after reset");
      expect_offer(21, 2, 8, "R1 level type kept");
      cfg(5, 2, 8, 8);
      check_empty("R1 level kept done");
      expect_offer(17, 3, 3, "R1 message type kept");
      cfg(1, 3, 3, 3);
      check_empty("R1 message kept done");
      type_vld = 1'b1; type_idx = IW'(4); type_lvl = 1'b0;
      settle(1);
      type_vld = 1'b0;
      check(err_retype == 1'b1, "R1 type survives soft reset", err_retype, 1);

      settle(3);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule